// File: doc/BRIEF.md
# CSR Instruction Access Controller

This block sits between the instruction decode stage of one hart and its control-and-status register file. It executes the six atomic read-modify-write instructions: swap, bit-set and bit-clear, each in a register-operand and a 5-bit-immediate form. It takes the instruction word together with the register operand. It drives the 12-bit register address to the register file and reads back the current value, a present flag and a writable-bit mask for that address. In the same cycle it raises a read strobe and a write strobe with the merged write value, so the read-modify-write is atomic.

The read and write strobes are gated by the register-index and immediate fields of the instruction, never by operand data. A swap whose destination is x0 performs no read at all. A set or clear whose source field is zero performs no write at all. A read-only fault is raised only when a write is really attempted. The old register value is returned to the destination register one clock later, through registered write-back outputs. The illegal-instruction flag is registered in the same way.

Top module: `csr_acc_ctrl`

## Requirements
- R1: `csr_addr` equals instruction bits [31:20] in every cycle; `csr_re` and `csr_we` stay low whenever `instr_valid` is low.
- R2: Only opcode 7'b1110011 with funct3 001 (swap), 010 (set), 011 (clear), 101 (swap-immediate), 110 (set-immediate) or 111 (clear-immediate) is accepted; any other valid word sets `illegal` in the next cycle, with no strobe and no write-back.
- R3: A swap writes the operand and reads the old value; with rd field (bits [11:7]) nonzero, `rd_we`, `rd_idx` = rd and `rd_data` = old value appear one cycle later; with rd = 0 the swap raises no read strobe and no write-back.
- R4: Set writes old OR operand; clear writes old AND NOT operand.
- R5: Bits of the written value where `csr_wmask` is 0 keep the old CSR value for every form.
- R6: Set or clear with source field (bits [19:15]) equal to 0, in register or immediate form, raises no write strobe and no illegal flag, even at a read-only address.
- R7: Set or clear with a nonzero source field and a zero operand value still writes, with the unchanged old value.
- R8: Set and clear always raise the read strobe, whatever the rd and source fields.
- R9: The register forms take the operand as zero when the source field is 0, whatever `rs1_val` holds, so a swap from x0 writes zero.
- R10: The immediate forms use bits [19:15] zero-extended to XLEN as the operand.
- R11: An address with bits [11:10] = 2'b11 is read-only; a write attempt to it raises `illegal` next cycle and suppresses both strobes and the write-back.
- R12: When `csr_present` is low, any valid CSR instruction raises `illegal` next cycle with no strobes and no write-back.
- R13: `rd_we` and `illegal` are registered, low after reset, and high for exactly the cycle after the instruction that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | XLEN | Value of the source register |
| csr_addr | output | 12 | CSR address |
| csr_re | output | 1 | CSR read strobe |
| csr_we | output | 1 | CSR write strobe |
| csr_wdata | output | XLEN | CSR write value |
| csr_rdata | input | XLEN | Current value of the addressed CSR |
| csr_present | input | 1 | Addressed CSR is implemented |
| csr_wmask | input | XLEN | Writable bits of the addressed CSR |
| rd_we | output | 1 | Destination write-back enable |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | XLEN | Old CSR value for the destination |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
The assertions watch, on every cycle, that no write strobe ever reaches a read-only address and that strobes only appear with a valid word. They also check that a written value never changes a non-writable bit, and that each write-back carries the index and the CSR value of the cycle before. Whether a strobe is correctly withheld for a zero source field or an x0 destination, and whether set, clear and swap merge the right operand, depends on the instruction fields. Only the bench's directed and random instruction streams, compared against its own reference model, can show that.

// File: rtl/csr_acc_pkg.sv
package csr_acc_pkg;

  localparam logic [6:0] SYS_OPCODE = 7'b1110011;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned REG_W  = 5;

  typedef enum logic [1:0] {
    CSR_OP_SWAP = 2'd0,
    CSR_OP_SET  = 2'd1,
    CSR_OP_CLR  = 2'd2,
    CSR_OP_NONE = 2'd3
  } csr_op_e;

  typedef struct packed {
    logic              opc_ok;
    csr_op_e           op;
    logic              use_imm;
    logic [ADDR_W-1:0] addr;
    logic [REG_W-1:0]  rd;
    logic [REG_W-1:0]  src;
  } csr_dec_t;

  function automatic csr_op_e op_of_funct3(input logic [2:0] f3);
    csr_op_e o;
    case (f3[1:0])
      2'b01:   o = CSR_OP_SWAP;
      2'b10:   o = CSR_OP_SET;
      2'b11:   o = CSR_OP_CLR;
      default: o = CSR_OP_NONE;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/csr_acc_decode.sv
module csr_acc_decode
  import csr_acc_pkg::*;
(
  input  logic [31:0] instr,
  output csr_dec_t    dec
);
  always_comb begin
    dec.opc_ok  = (instr[6:0] == SYS_OPCODE);
    dec.op      = op_of_funct3(instr[14:12]);
    dec.use_imm = instr[14];
    dec.addr    = instr[31:20];
    dec.rd      = instr[11:7];
    dec.src     = instr[19:15];
  end
endmodule

// File: rtl/csr_acc_policy.sv
module csr_acc_policy
  import csr_acc_pkg::*;
#(
  parameter logic [1:0] RO_CODE = 2'b11
) (
  input  logic             valid,
  input  logic             opc_ok,
  input  csr_op_e          op,
  input  logic [REG_W-1:0] rd,
  input  logic [REG_W-1:0] src,
  input  logic [1:0]       addr_top,
  input  logic             present,
  output logic             rd_attempt,
  output logic             wr_attempt,
  output logic             ro_hit,
  output logic             fault,
  output logic             re,
  output logic             we,
  output logic             wb_now
);
  logic known;
  logic go;

  always_comb begin
    known = opc_ok && (op != CSR_OP_NONE);
    if (op == CSR_OP_SWAP) begin
      rd_attempt = (rd != '0);
      wr_attempt = 1'b1;
    end else begin
      rd_attempt = 1'b1;
      wr_attempt = (src != '0);
    end
    ro_hit = (addr_top == RO_CODE);
    fault  = valid && (!known || !present || (wr_attempt && ro_hit));
    go     = valid && !fault;
    re     = go && rd_attempt;
    we     = go && wr_attempt;
    wb_now = re && (rd != '0);
  end
endmodule

// File: rtl/csr_acc_datapath.sv
module csr_acc_datapath
  import csr_acc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  csr_op_e          op,
  input  logic             use_imm,
  input  logic [REG_W-1:0] src,
  input  logic [XLEN-1:0]  rs1_val,
  input  logic [XLEN-1:0]  old_val,
  input  logic [XLEN-1:0]  wmask,
  output logic [XLEN-1:0]  operand,
  output logic [XLEN-1:0]  wdata
);
  localparam int unsigned PAD_W = XLEN - REG_W;

  function automatic logic [XLEN-1:0] raw_update(
    input csr_op_e op_i, input logic [XLEN-1:0] old_i, input logic [XLEN-1:0] opnd_i);
    logic [XLEN-1:0] r;
    case (op_i)
      CSR_OP_SWAP: r = opnd_i;
      CSR_OP_SET:  r = old_i | opnd_i;
      CSR_OP_CLR:  r = old_i & ~opnd_i;
      default:     r = old_i;
    endcase
    return r;
  endfunction

  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] raw;

  assign imm_ext = {{PAD_W{1'b0}}, src};

  always_comb begin
    if (use_imm)          operand = imm_ext;
    else if (src == '0)   operand = '0;
    else                  operand = rs1_val;
    raw = raw_update(op, old_val, operand);
  end

  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    assign wdata[b] = wmask[b] ? raw[b] : old_val[b];
  end
endmodule

// File: rtl/csr_acc_wb.sv
module csr_acc_wb
  import csr_acc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_now,
  input  logic             fault_now,
  input  logic [REG_W-1:0] rd_now,
  input  logic [XLEN-1:0]  old_now,
  output logic             rd_we,
  output logic [REG_W-1:0] rd_idx,
  output logic [XLEN-1:0]  rd_data,
  output logic             illegal
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_we   <= 1'b0;
      rd_idx  <= '0;
      rd_data <= '0;
      illegal <= 1'b0;
    end else begin
      rd_we   <= wb_now;
      illegal <= fault_now;
      if (wb_now) begin
        rd_idx  <= rd_now;
        rd_data <= old_now;
      end
    end
  end
endmodule

// File: rtl/csr_acc_ctrl.sv
module csr_acc_ctrl
  import csr_acc_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter logic [1:0]  RO_CODE = 2'b11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1_val,
  output logic [11:0]     csr_addr,
  output logic            csr_re,
  output logic            csr_we,
  output logic [XLEN-1:0] csr_wdata,
  input  logic [XLEN-1:0] csr_rdata,
  input  logic            csr_present,
  input  logic [XLEN-1:0] csr_wmask,
  output logic            rd_we,
  output logic [4:0]      rd_idx,
  output logic [XLEN-1:0] rd_data,
  output logic            illegal
);
  csr_dec_t        dec;
  logic            rd_attempt;
  logic            wr_attempt;
  logic            ro_hit;
  logic            fault_now;
  logic            wb_now;
  logic [XLEN-1:0] operand;

  csr_acc_decode u_decode (
    .instr (instr),
    .dec   (dec)
  );

  csr_acc_policy #(.RO_CODE(RO_CODE)) u_policy (
    .valid      (instr_valid),
    .opc_ok     (dec.opc_ok),
    .op         (dec.op),
    .rd         (dec.rd),
    .src        (dec.src),
    .addr_top   (dec.addr[11:10]),
    .present    (csr_present),
    .rd_attempt (rd_attempt),
    .wr_attempt (wr_attempt),
    .ro_hit     (ro_hit),
    .fault      (fault_now),
    .re         (csr_re),
    .we         (csr_we),
    .wb_now     (wb_now)
  );

  csr_acc_datapath #(.XLEN(XLEN)) u_data (
    .op      (dec.op),
    .use_imm (dec.use_imm),
    .src     (dec.src),
    .rs1_val (rs1_val),
    .old_val (csr_rdata),
    .wmask   (csr_wmask),
    .operand (operand),
    .wdata   (csr_wdata)
  );

  csr_acc_wb #(.XLEN(XLEN)) u_wb (
    .clk       (clk),
    .rst_n     (rst_n),
    .wb_now    (wb_now),
    .fault_now (fault_now),
    .rd_now    (dec.rd),
    .old_now   (csr_rdata),
    .rd_we     (rd_we),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .illegal   (illegal)
  );

  assign csr_addr = dec.addr;
endmodule

// File: rtl/csr_acc_ctrl_chk.sv
module csr_acc_ctrl_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_valid,
  input logic [31:0]     instr,
  input logic [11:0]     csr_addr,
  input logic            csr_re,
  input logic            csr_we,
  input logic [XLEN-1:0] csr_wdata,
  input logic [XLEN-1:0] csr_rdata,
  input logic [XLEN-1:0] csr_wmask,
  input logic            rd_we,
  input logic [4:0]      rd_idx,
  input logic [XLEN-1:0] rd_data,
  input logic            illegal,
  input logic            rd_attempt,
  input logic            wr_attempt
);
  AST_ADDR_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    csr_addr == instr[31:20]); // R1
  AST_STROBE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_re || csr_we) |-> instr_valid); // R1
  AST_RO_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |-> (csr_addr[11:10] != 2'b11)); // R11
  AST_LOCKED_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |-> (((csr_wdata ^ csr_rdata) & ~csr_wmask) == '0)); // R5
  AST_STROBES_FOLLOW_ATTEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    ((csr_re && !rd_attempt) || (csr_we && !wr_attempt)) == 1'b0); // R6
  AST_WB_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> ($past(csr_re) && rd_idx == $past(instr[11:7]) && rd_idx != 5'd0)); // R3
  AST_WB_OLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> rd_data == $past(csr_rdata)); // R3
  AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!rd_we && $past(instr_valid) && !$past(csr_re) && !$past(csr_we))); // R11
endmodule

bind csr_acc_ctrl csr_acc_ctrl_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr       (instr),
  .csr_addr    (csr_addr),
  .csr_re      (csr_re),
  .csr_we      (csr_we),
  .csr_wdata   (csr_wdata),
  .csr_rdata   (csr_rdata),
  .csr_wmask   (csr_wmask),
  .rd_we       (rd_we),
  .rd_idx      (rd_idx),
  .rd_data     (rd_data),
  .illegal     (illegal),
  .rd_attempt  (rd_attempt),
  .wr_attempt  (wr_attempt)
);

// File: tb/csr_acc_ctrl_bench.sv
module csr_acc_ctrl_bench;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            instr_valid = 1'b0;
  logic [31:0]     instr = '0;
  logic [XLEN-1:0] rs1_val = '0;
  logic [11:0]     csr_addr;
  logic            csr_re, csr_we;
  logic [XLEN-1:0] csr_wdata;
  logic [XLEN-1:0] csr_rdata = '0;
  logic            csr_present = 1'b0;
  logic [XLEN-1:0] csr_wmask = '0;
  logic            rd_we;
  logic [4:0]      rd_idx;
  logic [XLEN-1:0] rd_data;
  logic            illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  csr_acc_ctrl #(.XLEN(XLEN)) u_csr_acc_ctrl (.*);

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(logic [2:0] f3, logic [4:0] rd, logic [4:0] src,
                                      logic [11:0] addr);
    return {addr, src, f3, rd, 7'b1110011};
  endfunction

  task automatic run_op(string tag, logic [31:0] ins, logic [31:0] rv, logic [31:0] old,
                        logic [31:0] wm, bit pres);
    int kind;
    bit known, want_rd, want_wr, bad, e_re, e_we, e_wb;
    logic [31:0] opnd, nv;
    @(negedge clk);
    instr_valid = 1'b1; instr = ins; rs1_val = rv;
    csr_rdata = old; csr_wmask = wm; csr_present = pres;
    kind = ins[13:12] == 2'b01 ? 0 : ins[13:12] == 2'b10 ? 1 : ins[13:12] == 2'b11 ? 2 : -1;
    known = (ins[6:0] == 7'h73) && (kind >= 0);
    if (ins[14]) opnd = 32'(ins[19:15]);
    else if (ins[19:15] == 5'd0) opnd = 32'd0;
    else opnd = rv;
    want_rd = (kind == 0) ? (ins[11:7] != 0) : 1'b1;
    want_wr = (kind == 0) ? 1'b1 : (ins[19:15] != 0);
    bad = !known || !pres || (want_wr && ins[31:30] == 2'b11);
    for (int b = 0; b < 32; b++) begin
      if (!wm[b]) nv[b] = old[b];
      else if (kind == 0) nv[b] = opnd[b];
      else if (kind == 1) nv[b] = old[b] | opnd[b];
      else nv[b] = old[b] & !opnd[b];
    end
    e_re = !bad && want_rd;
    e_we = !bad && want_wr;
    e_wb = e_re && (ins[11:7] != 0);
    #1;
    chk(tag, "csr_addr", 32'(csr_addr), 32'(ins[31:20]));
    chk(tag, "csr_re", 32'(csr_re), 32'(e_re));
    chk(tag, "csr_we", 32'(csr_we), 32'(e_we));
    if (e_we) chk(tag, "csr_wdata", csr_wdata, nv);
    @(posedge clk); #1;
    instr_valid = 1'b0;
    chk(tag, "rd_we", 32'(rd_we), 32'(e_wb));
    chk(tag, "illegal", 32'(illegal), 32'(bad));
    if (e_wb) begin
      chk(tag, "rd_idx", 32'(rd_idx), 32'(ins[11:7]));
      chk(tag, "rd_data", rd_data, old);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R13", "rd_we in reset", 32'(rd_we), 0);
    chk("R13", "illegal in reset", 32'(illegal), 0);
    @(negedge clk); rst_n = 1'b1;
    instr = enc(3'b010, 5'd4, 5'd2, 12'h340); csr_present = 1'b1; csr_wmask = '1;
    #1;
    chk("R1", "csr_re idle", 32'(csr_re), 0);
    chk("R1", "csr_we idle", 32'(csr_we), 0);
    chk("R1", "csr_addr idle", 32'(csr_addr), 32'h340);
    // swap forms
    run_op("R3", enc(3'b001, 5'd5, 5'd3, 12'h300), 32'hA5A50F0F, 32'h12345678, '1, 1);
    run_op("R3", enc(3'b001, 5'd0, 5'd3, 12'h301), 32'h0BADF00D, 32'h87654321, '1, 1);
    run_op("R9", enc(3'b001, 5'd6, 5'd0, 12'h302), 32'hFFFFFFFF, 32'h5555AAAA, '1, 1);
    // set / clear
    run_op("R4", enc(3'b010, 5'd7, 5'd8, 12'h303), 32'h0F00000F, 32'h000000F0, '1, 1);
    run_op("R4", enc(3'b011, 5'd7, 5'd8, 12'h304), 32'h00FF00FF, 32'hFFFF0000, '1, 1);
    run_op("R5", enc(3'b010, 5'd9, 5'd8, 12'h305), 32'hFFFFFFFF, 32'h00000000, 32'h0000FFFF, 1);
    run_op("R5", enc(3'b011, 5'd9, 5'd8, 12'h306), 32'hFFFFFFFF, 32'hF0F0F0F0, 32'hFF000000, 1);
    run_op("R5", enc(3'b001, 5'd9, 5'd8, 12'h307), 32'h00000000, 32'hFFFFFFFF, 32'h0000000F, 1);
    // zero source fields
    run_op("R6", enc(3'b010, 5'd3, 5'd0, 12'hC00), 32'h12345678, 32'hCAFEBABE, '1, 1);
    run_op("R6", enc(3'b111, 5'd3, 5'd0, 12'hC02), 32'h0, 32'h0000BEEF, '1, 1);
    run_op("R7", enc(3'b010, 5'd2, 5'd7, 12'h308), 32'h0, 32'h13579BDF, '1, 1);
    run_op("R8", enc(3'b011, 5'd0, 5'd7, 12'h309), 32'h1, 32'h00000003, '1, 1);
    run_op("R8", enc(3'b110, 5'd0, 5'd0, 12'h30A), 32'h0, 32'h00000010, '1, 1);
    // immediates
    run_op("R10", enc(3'b101, 5'd1, 5'd31, 12'h30B), 32'hFFFFFFFF, 32'h80000000, '1, 1);
    run_op("R10", enc(3'b110, 5'd1, 5'd21, 12'h30C), 32'hFFFFFFFF, 32'h00000100, '1, 1);
    run_op("R10", enc(3'b111, 5'd1, 5'd3, 12'h30D), 32'hFFFFFFFF, 32'h0000000F, '1, 1);
    // faults
    run_op("R11", enc(3'b001, 5'd4, 5'd3, 12'hC01), 32'h1, 32'h22222222, '1, 1);
    run_op("R11", enc(3'b010, 5'd4, 5'd3, 12'hF14), 32'h1, 32'h22222222, '1, 1);
    run_op("R11", enc(3'b101, 5'd0, 5'd0, 12'hC03), 32'h0, 32'h22222222, '1, 1);
    run_op("R12", enc(3'b010, 5'd4, 5'd0, 12'h7C0), 32'h0, 32'h33333333, '1, 0);
    run_op("R2", enc(3'b000, 5'd4, 5'd1, 12'h300), 32'h1, 32'h44444444, '1, 1);
    run_op("R2", enc(3'b100, 5'd4, 5'd1, 12'h300), 32'h1, 32'h44444444, '1, 1);
    run_op("R2", {12'h300, 5'd1, 3'b001, 5'd4, 7'b0110011}, 32'h1, 32'h44444444, '1, 1);
    // back-to-back then idle: flags last one cycle
    @(negedge clk); #1;
    chk("R13", "rd_we cleared", 32'(rd_we), 0);
    @(posedge clk); #1;
    chk("R13", "rd_we idle", 32'(rd_we), 0);
    chk("R13", "illegal idle", 32'(illegal), 0);
    // random mix of all forms
    for (int i = 0; i < 600; i++) begin
      logic [31:0] w;
      w = $urandom;
      if ($urandom_range(0, 7) != 0) w[6:0] = 7'h73;
      if ($urandom_range(0, 3) == 0) w[19:15] = 5'd0;
      if ($urandom_range(0, 3) == 0) w[11:7] = 5'd0;
      run_op("Rmix", w, ($urandom_range(0, 5) == 0) ? 32'h0 : $urandom, $urandom,
             ($urandom_range(0, 1) == 0) ? '1 : $urandom, $urandom_range(0, 9) != 0);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule